// File: doc/BRIEF.md
# Three-Phase Cyclic Bit Transmitter

This block is the sending end of a link that tolerates lost bits. The data are carried by changes of symbol, not by the symbol values. The channel has three symbols, A, B and C, placed on a ring. When the block is asked to send a zero, it moves one place around the ring. When it is asked to send a one, it moves two places. The current symbol stays on its output line until the receiver acknowledges it. The block then waits for the next request.

Any input that breaks the protocol raises a registered error strobe. This covers a request that arrives while a symbol is still waiting for its acknowledge, an acknowledge that nothing asked for, and both request lines on at once. After an error the block stays where it was, so the link keeps running.

Top module: `tri_phase_tx`

## Requirements
- R1: The request lines encode a bit as follows. `reqZero` high with `reqOne` low asks to send 0. `reqOne` high with `reqZero` low asks to send 1. Both high is a bad request. Both low is no request. `ack` is the receiver's acknowledge.
- R2: From idle after reset, the block stays idle while there is no request. A send-0 request moves it to symbol A, and a send-1 request moves it to symbol B.
- R3: While idle, a cycle with `ack` high or with a bad request produces an error and leaves the block idle.
- R4: While a symbol is being sent, its output (`symA`, `symB` or `symC`) is high in every cycle in which `ack` is low. All three outputs are low in a cycle in which `ack` is high.
- R5: While a symbol is being sent, a cycle with either request line high produces an error and does not change the symbol. A cycle with `ack` high ends the send, whether or not a request is present.
- R6: After an acknowledge, a send-0 request moves to the next symbol in the ring order A→B→C→A. A send-1 request moves two places: A→C, B→A, C→B.
- R7: While waiting after an acknowledge, a cycle with `ack` high or with a bad request produces an error. The block keeps waiting, and it keeps its ring position for the next step.
- R8: `errPulse` is high for exactly the one cycle that follows each offending input cycle. It is low otherwise.
- R9: At most one symbol output is high at any time. None is high while idle or while waiting after an acknowledge.
- R10: A synchronous reset returns the block to idle with every output low, even in the middle of a send.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqZero | input | 1 | Request to send a 0 bit |
| reqOne | input | 1 | Request to send a 1 bit |
| ack | input | 1 | Acknowledge from the receiver |
| symA | output | 1 | Channel symbol A |
| symB | output | 1 | Channel symbol B |
| symC | output | 1 | Channel symbol C |
| errPulse | output | 1 | One-cycle protocol error strobe |

## Verification
The hardest case to reach is an error that leaves the ring position untouched. The only way to see that position from the ports is the symbol chosen by the next good request. To reach this case, the stimulus first walks the ring to a known symbol. It then injects an extra acknowledge, a bad request, or a request during a send, and finally sends one more bit. The symbol that appears must be the correct step from the position held before the error. A second case is an acknowledge that arrives together with a request during a send. This one cycle must both end the send and flag an error.

// File: rtl/tri_phase_pkg.sv
package tri_phase_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_HOLD = 2'd2
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFirst;  // first symbol after idle
    logic stepNext;   // advance around the ring
    logic dataBit;    // bit value of the accepted request
    logic drive;      // a symbol is on the channel
    logic flagErr;    // protocol violation this cycle
  } txStrobe_t;

endpackage

// File: rtl/tri_phase_ctrl.sv
module tri_phase_ctrl
  import tri_phase_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reqZero,
  input  logic      reqOne,
  input  logic      ack,
  output txStrobe_t strb
);

  txState_e stateQ, stateNext;

  logic wantZero, wantOne, badReq, anyReq, goodReq;

  assign wantZero = reqZero & ~reqOne;
  assign wantOne  = reqOne & ~reqZero;
  assign badReq   = reqZero & reqOne;
  assign anyReq   = reqZero | reqOne;
  assign goodReq  = wantZero | wantOne;

  always_comb begin
    stateNext = stateQ;
    strb      = '0;
    strb.drive = (stateQ == ST_SEND);
    case (stateQ)
      ST_IDLE: begin
        if (ack || badReq) begin
          strb.flagErr = 1'b1;
        end else if (goodReq) begin
          strb.loadFirst = 1'b1;
          strb.dataBit   = wantOne;
          stateNext      = ST_SEND;
        end
      end
      ST_SEND: begin
        if (anyReq) strb.flagErr = 1'b1;
        if (ack) stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (ack || badReq) begin
          strb.flagErr = 1'b1;
        end else if (goodReq) begin
          strb.stepNext = 1'b1;
          strb.dataBit  = wantOne;
          stateNext     = ST_SEND;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateNext;
  end

  // R2
  idle_start_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_IDLE && !ack && (reqZero != reqOne)) |=> (stateQ == ST_SEND));

  // R3
  idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_IDLE && (ack || (reqZero && reqOne))) |=> (stateQ == ST_IDLE));

  // R5
  send_end_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_SEND && ack) |=> (stateQ == ST_HOLD));

  // R5
  send_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_SEND && !ack) |=> (stateQ == ST_SEND));

  // R7
  hold_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_HOLD && (ack || (reqZero && reqOne))) |=> (stateQ == ST_HOLD));

  // R6
  hold_move_chk: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_HOLD && !ack && (reqZero != reqOne)) |=> (stateQ == ST_SEND));

endmodule

// File: rtl/tri_phase_dp.sv
module tri_phase_dp
  import tri_phase_pkg::*;
#(
  parameter int SYM_COUNT = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ack,
  input  txStrobe_t            strb,
  output logic [SYM_COUNT-1:0] symVec,
  output logic                 errPulse
);

  localparam int POS_W = (SYM_COUNT > 1) ? $clog2(SYM_COUNT) : 1;

  logic [POS_W-1:0] posQ, posNext;
  logic [POS_W:0]   sumRaw, sumWrap;
  logic             errQ;

  always_comb begin
    sumRaw  = {1'b0, posQ} + (POS_W+1)'(1) + {{POS_W{1'b0}}, strb.dataBit};
    sumWrap = (sumRaw >= (POS_W+1)'(SYM_COUNT)) ? (sumRaw - (POS_W+1)'(SYM_COUNT)) : sumRaw;
    posNext = posQ;
    if (strb.loadFirst)     posNext = strb.dataBit ? POS_W'(1) : POS_W'(0);
    else if (strb.stepNext) posNext = sumWrap[POS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      posQ <= '0;
      errQ <= 1'b0;
    end else begin
      posQ <= posNext;
      errQ <= strb.flagErr;
    end
  end

  assign errPulse = errQ;

  genvar gi;
  generate
    for (gi = 0; gi < SYM_COUNT; gi++) begin : g_sym
      localparam int NEXT_ONE = (gi + 1) % SYM_COUNT;
      localparam int NEXT_TWO = (gi + 2) % SYM_COUNT;

      assign symVec[gi] = strb.drive && !ack && (posQ == POS_W'(gi));

      // R6
      step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (strb.stepNext && !strb.dataBit && posQ == POS_W'(gi)) |=> (posQ == POS_W'(NEXT_ONE)));

      // R6
      step_two_chk: assert property (@(posedge clk) disable iff (rst)
        (strb.stepNext && strb.dataBit && posQ == POS_W'(gi)) |=> (posQ == POS_W'(NEXT_TWO)));
    end
  endgenerate

  // R9
  sym_excl_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(symVec));

  // R5
  send_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.drive && !strb.loadFirst && !strb.stepNext) |=> $stable(posQ));

endmodule

// File: rtl/tri_phase_tx.sv
module tri_phase_tx
  import tri_phase_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic reqZero,
  input  logic reqOne,
  input  logic ack,
  output logic symA,
  output logic symB,
  output logic symC,
  output logic errPulse
);

  txStrobe_t  strb;
  logic [2:0] symVec;

  tri_phase_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqZero (reqZero),
    .reqOne  (reqOne),
    .ack     (ack),
    .strb    (strb)
  );

  tri_phase_dp #(.SYM_COUNT(3)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ack      (ack),
    .strb     (strb),
    .symVec   (symVec),
    .errPulse (errPulse)
  );

  assign symA = symVec[0];
  assign symB = symVec[1];
  assign symC = symVec[2];

  // R4
  ack_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ack |-> !(symA || symB || symC));

endmodule

// File: tb/tri_phase_tx_bench.sv
module tri_phase_tx_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqZero = 1'b0, reqOne = 1'b0, ack = 1'b0;
  logic symA, symB, symC, errPulse;

  int vecCount  = 0;
  int missCount = 0;
  bit doneFlag  = 0;

  localparam logic [2:0] S_A = 3'b100, S_B = 3'b010, S_C = 3'b001, S_N = 3'b000;

  always #10 clk = ~clk;  // 50 MHz

  tri_phase_tx u_tri_phase_tx (
    .clk(clk), .rst(rst), .reqZero(reqZero), .reqOne(reqOne), .ack(ack),
    .symA(symA), .symB(symB), .symC(symC), .errPulse(errPulse)
  );

  // {symA,symB,symC,errPulse} against expected
  task automatic chk(input string tag, input logic [2:0] expSym, input logic expErr);
    logic [3:0] got, want;
    got  = {symA, symB, symC, errPulse};
    want = {expSym, expErr};
    vecCount++;
    if (got !== want) begin
      missCount++;
      $display("FAIL %s: got %b expected %b (symA symB symC err)", tag, got, want);
    end
  endtask

  // inputs change mid-cycle; errPulse then shows the previous cycle's verdict
  task automatic drive(input logic z, input logic o, input logic a);
    @(negedge clk);
    reqZero = z; reqOne = o; ack = a;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; reqZero = 0; reqOne = 0; ack = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one full bit: request, symbol shown, ack, wait
  task automatic sendBit(input logic b, input logic [2:0] expSym, input string tag);
    drive(!b, b, 0);
    drive(0, 0, 0);
    chk(tag, expSym, 0);
    drive(0, 0, 1);
    chk("R4 ack cycle", S_N, 0);
    drive(0, 0, 0);
    chk("R9 after ack", S_N, 0);
  endtask

  task automatic t_reset();
    doReset();
    drive(0, 0, 0);
    chk("R10 reset state", S_N, 0);
  endtask

  task automatic t_idleQuiet();
    doReset();
    for (int k = 0; k < 5; k++) drive(0, 0, 0);
    chk("R2 idle without request", S_N, 0);
  endtask

  task automatic t_ringWalk();
    doReset();
    sendBit(0, S_A, "R2 first zero gives A");
    sendBit(1, S_C, "R6 A plus one-bit gives C");
    sendBit(1, S_B, "R6 C plus one-bit gives B");
    sendBit(0, S_C, "R6 B plus zero-bit gives C");
    sendBit(0, S_A, "R6 C plus zero-bit gives A");
    sendBit(0, S_B, "R6 A plus zero-bit gives B");
    sendBit(1, S_A, "R6 B plus one-bit gives A");
  endtask

  task automatic t_firstOne();
    doReset();
    sendBit(1, S_B, "R2 first one gives B");
  endtask

  task automatic t_idleErr();
    doReset();
    drive(0, 0, 1);
    drive(0, 0, 0);
    chk("R3 idle ack error", S_N, 1);
    drive(0, 0, 0);
    chk("R8 error lasts one cycle", S_N, 0);
    drive(1, 1, 0);
    drive(0, 0, 0);
    chk("R1 both requests is bad in idle", S_N, 1);
    drive(0, 0, 0);
    sendBit(0, S_A, "R3 still idle after error");
  endtask

  task automatic t_sendErr();
    doReset();
    drive(1, 0, 0);
    for (int k = 0; k < 3; k++) begin
      drive(0, 0, 0);
      chk("R4 symbol held while ack low", S_A, 0);
    end
    drive(0, 1, 0);
    chk("R5 request during send keeps symbol", S_A, 0);
    drive(0, 0, 0);
    chk("R5 request during send errors", S_A, 1);
    drive(1, 1, 0);
    drive(0, 0, 0);
    chk("R5 bad request during send errors", S_A, 1);
    drive(0, 0, 1);
    drive(0, 0, 0);
    chk("R9 idle lines after ack", S_N, 0);
    sendBit(1, S_C, "R5 position kept through send errors");
  endtask

  task automatic t_ackWithReq();
    doReset();
    drive(0, 1, 0);
    drive(0, 0, 0);
    chk("R2 send-1 from idle", S_B, 0);
    drive(1, 0, 1);
    chk("R4 ack hides symbol", S_N, 0);
    drive(0, 0, 0);
    chk("R5 ack with request ends send and errors", S_N, 1);
    sendBit(0, S_C, "R6 step after combined ack");
  endtask

  task automatic t_holdErr();
    doReset();
    sendBit(1, S_B, "R2 start at B");
    drive(0, 0, 1);
    drive(0, 0, 0);
    chk("R7 extra ack errors", S_N, 1);
    drive(1, 1, 0);
    drive(0, 0, 0);
    chk("R7 bad request while waiting errors", S_N, 1);
    drive(0, 0, 1);
    drive(0, 0, 1);
    chk("R8 back-to-back ack errors each cycle", S_N, 1);
    drive(0, 0, 0);
    chk("R8 strobe drops", S_N, 1);
    drive(0, 0, 0);
    chk("R8 strobe clear", S_N, 0);
    sendBit(0, S_C, "R7 position kept while waiting");
  endtask

  task automatic t_resetMid();
    doReset();
    drive(1, 0, 0);
    drive(0, 0, 0);
    chk("R2 symbol A up", S_A, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R10 reset mid-send clears outputs", S_N, 0);
    sendBit(1, S_B, "R10 restart from idle");
  endtask

  initial begin
    t_reset();
    t_idleQuiet();
    t_firstOne();
    t_ringWalk();
    t_idleErr();
    t_sendErr();
    t_ackWithReq();
    t_holdErr();
    t_resetMid();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!doneFlag) begin
      doneFlag = 1;
      vecCount++;
      missCount++;
      $display("FAIL watchdog: got running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

endmodule